// File: doc/BRIEF.md
# Pipelined Program Sequencer with Hardware Loops

This block produces the instruction fetch address for a three-stage fetch, decode and execute pipeline. It keeps the address held in each stage and marks stages whose contents have been cancelled. Control fields arrive for the instruction that is currently in execute. They select a jump, a call, a return or a loop start, together with a condition and a delayed-form bit. A PC stack holds return addresses and the first address of each active loop. A loop stack holds the last address of each loop, its exit mode and its remaining count.

The test for ending a loop is made while the loop's last address is being fetched. At that point the instruction is still two cycles from execute. The block can therefore fetch the top of the loop, or the next address after the loop, in the following cycle with no bubble. A non-delayed branch cancels the two younger instructions. A delayed branch lets both of them complete. Each form pushes a different return address.

Top module: `pipeSequencer`

## Requirements
- R1: While rstN is low, fetchAddr equals RESET_ADDR, squashDecode and squashExec are 1, and all four stack flags are 0.
- R2: In each cycle without stall, decodeAddr takes the previous fetchAddr and execAddr takes the previous decodeAddr. In sequential flow, fetchAddr increases by one.
- R3: While stall is 1, the three stage addresses hold their values and the control fields have no effect.
- R4: opKind encodes 0 as none, 1 as jump, 2 as call, 3 as return and 4 as loop start. When a jump, call or return is taken with delayed=0, the next fetchAddr is the destination and both younger stages are squashed in the following cycle.
- R5: When a jump, call or return is taken with delayed=1, nothing is squashed and the next fetchAddr is the destination.
- R6: A branch is taken when condGiven is 0 or condTrue is 1. A branch that is not taken leaves flow sequential and squashes nothing.
- R7: A call at address n pushes n+1 when delayed=0 and n+3 when delayed=1. A taken return fetches the popped address.
- R8: Control fields are ignored while the execute stage is squashed.
- R9: A loop start at address L with loopUseCnt=1 and count N runs the body L+1..loopEnd N times. Each fetch of loopEnd is followed directly by L+1 while passes remain, and by loopEnd+1 on exit.
- R10: A loop with loopUseCnt=0 exits when loopExitCond is 1 in the cycle that loopEnd is fetched. Otherwise it returns to its top.
- R11: When a jump, call, return or loop start acts in execute, the loop-end test for that cycle is skipped and the count is not decremented.
- R12: On loop exit, the loop's entries on both stacks are popped in the same cycle.
- R13: A push onto a full stack sets its sticky overflow flag and leaves the stack unchanged. A pop from an empty stack sets its sticky underflow flag, and a return with an empty PC stack does not redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze the pipeline |
| opKind | input | 3 | Operation of the instruction in execute |
| delayed | input | 1 | Delayed branch form |
| condGiven | input | 1 | Branch carries a condition |
| condTrue | input | 1 | Condition evaluates true |
| branchTarget | input | ADDR_W | Jump or call destination |
| loopEnd | input | ADDR_W | Last address of a starting loop |
| loopCount | input | CNT_W | Pass count of a starting loop |
| loopUseCnt | input | 1 | Loop ends on its counter |
| loopExitCond | input | 1 | Exit condition for condition-ended loops |
| fetchAddr | output | ADDR_W | Address being fetched |
| decodeAddr | output | ADDR_W | Address in decode |
| execAddr | output | ADDR_W | Address in execute |
| squashDecode | output | 1 | Decode slot holds no valid instruction |
| squashExec | output | 1 | Execute slot holds no valid instruction |
| pcOverflow | output | 1 | PC stack overflow, sticky |
| pcUnderflow | output | 1 | PC stack underflow, sticky |
| loopOverflow | output | 1 | Loop stack overflow, sticky |
| loopUnderflow | output | 1 | Loop stack underflow, sticky |

## Verification
Two functions can meet in one cycle: a branch acting in execute and the loop-end test acting at fetch. The bench places a non-delayed jump, aimed at the loop top, two instructions before the last address of a counted loop. As a result, the jump executes in the same cycle that loopEnd is fetched. The bench then compares the fetch sequence with one that contains an extra full pass. That pass shows that the branch won, that the count was left alone, and that the loop still exits cleanly.

// File: rtl/seqPkg.sv
package seqPkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_LOOP = 3'd4
  } opKind_t;

  typedef enum logic [1:0] {
    NX_SEQ    = 2'd0,
    NX_TARGET = 2'd1,
    NX_STACK  = 2'd2
  } nextSel_t;

  typedef struct packed {
    logic     advance;
    logic     killYoung;
    logic     pcPush;
    logic     pcPop;
    logic     retPlus3;
    logic     loopPush;
    logic     loopPop;
    logic     loopDec;
    nextSel_t nextSel;
  } seqStrobe_t;
endpackage

// File: rtl/seqStack.sv
module seqStack #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic         wrTop,
  input  logic [W-1:0] din,
  output logic [W-1:0] topVal,
  output logic         isEmpty,
  output logic         overflow,
  output logic         underflow
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] cnt;
  logic [IW-1:0] topIdx;
  logic [IW-1:0] pushIdx;
  logic          isFull;

  assign isEmpty = (cnt == '0);
  assign isFull  = (cnt == PW'(DEPTH));
  assign topIdx  = IW'(cnt - 1'b1);
  assign pushIdx = IW'(cnt);
  assign topVal  = isEmpty ? '0 : mem[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (push) begin
      if (isFull) overflow <= 1'b1;
      else        cnt      <= cnt + 1'b1;
    end else if (pop) begin
      if (isEmpty) underflow <= 1'b1;
      else         cnt       <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !isFull)                 mem[pushIdx] <= din;
    else if (!push && !pop && wrTop && !isEmpty) mem[topIdx] <= din;
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic       stall,
  input  logic [2:0] opKind,
  input  logic       delayed,
  input  logic       condGiven,
  input  logic       condTrue,
  input  logic       loopExitCond,
  input  logic       execValid,
  input  logic       atLoopEnd,
  input  logic       loopTopUseCnt,
  input  logic       loopCntLast,
  input  logic       pcEmpty,
  output seqStrobe_t strb
);
  opKind_t op;
  logic    taken;
  logic    claim;
  logic    exitNow;

  assign op    = opKind_t'(opKind);
  assign taken = !condGiven || condTrue;

  always_comb begin
    strb         = '0;
    strb.nextSel = NX_SEQ;
    strb.advance = !stall;
    claim        = 1'b0;
    exitNow      = 1'b0;

    if (!stall && execValid) begin
      case (op)
        OP_JUMP, OP_CALL: begin
          if (taken) begin
            claim          = 1'b1;
            strb.nextSel   = NX_TARGET;
            strb.killYoung = !delayed;
            strb.pcPush    = (op == OP_CALL);
            strb.retPlus3  = delayed;
          end
        end
        OP_RET: begin
          if (taken) begin
            claim      = 1'b1;
            strb.pcPop = 1'b1;
            if (!pcEmpty) begin
              strb.nextSel   = NX_STACK;
              strb.killYoung = !delayed;
            end
          end
        end
        OP_LOOP: begin
          claim         = 1'b1;
          strb.loopPush = 1'b1;
          strb.pcPush   = 1'b1;
        end
        default: ;
      endcase
    end

    // loop-end test runs while the last address is in fetch
    if (!stall && !claim && atLoopEnd) begin
      exitNow = loopTopUseCnt ? loopCntLast : loopExitCond;
      if (exitNow) begin
        strb.loopPop = 1'b1;
        strb.pcPop   = 1'b1;
      end else begin
        strb.nextSel = NX_STACK;
        strb.loopDec = loopTopUseCnt;
      end
    end
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          CNT_W      = 16,
  parameter int          PC_DEPTH   = 16,
  parameter int          LOOP_DEPTH = 6,
  parameter int unsigned RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] loopEnd,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic              loopUseCnt,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] decodeAddr,
  output logic [ADDR_W-1:0] execAddr,
  output logic              decodeValid,
  output logic              execValid,
  output logic              atLoopEnd,
  output logic              loopTopUseCnt,
  output logic              loopCntLast,
  output logic              pcEmpty,
  output logic              pcOverflow,
  output logic              pcUnderflow,
  output logic              loopOverflow,
  output logic              loopUnderflow
);
  localparam int LE_W = ADDR_W + 1 + CNT_W;

  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] pcTop;
  logic [ADDR_W-1:0] pcPushVal;
  logic [LE_W-1:0]   loopTop;
  logic [LE_W-1:0]   loopDin;
  logic [ADDR_W-1:0] topEnd;
  logic [CNT_W-1:0]  topCnt;
  logic              loopEmpty;

  assign topEnd        = loopTop[LE_W-1 -: ADDR_W];
  assign loopTopUseCnt = loopTop[CNT_W];
  assign topCnt        = loopTop[CNT_W-1:0];
  assign loopCntLast   = (topCnt <= CNT_W'(1));
  assign atLoopEnd     = !loopEmpty && (fetchAddr == topEnd);

  assign pcPushVal = execAddr + (strb.retPlus3 ? ADDR_W'(3) : ADDR_W'(1));
  assign loopDin   = strb.loopPush ? {loopEnd, loopUseCnt, loopCount}
                                   : {topEnd, loopTopUseCnt, topCnt - CNT_W'(1)};

  always_comb begin
    case (strb.nextSel)
      NX_TARGET: nextAddr = target;
      NX_STACK:  nextAddr = pcTop;
      default:   nextAddr = fetchAddr + ADDR_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr   <= ADDR_W'(RESET_ADDR);
      decodeAddr  <= '0;
      execAddr    <= '0;
      decodeValid <= 1'b0;
      execValid   <= 1'b0;
    end else if (strb.advance) begin
      fetchAddr   <= nextAddr;
      decodeAddr  <= fetchAddr;
      execAddr    <= decodeAddr;
      decodeValid <= !strb.killYoung;
      execValid   <= decodeValid && !strb.killYoung;
    end
  end

  seqStack #(.W(ADDR_W), .DEPTH(PC_DEPTH)) pcStack (
    .clk(clk), .rstN(rstN),
    .push(strb.pcPush), .pop(strb.pcPop), .wrTop(1'b0),
    .din(pcPushVal), .topVal(pcTop), .isEmpty(pcEmpty),
    .overflow(pcOverflow), .underflow(pcUnderflow)
  );

  seqStack #(.W(LE_W), .DEPTH(LOOP_DEPTH)) loopStack (
    .clk(clk), .rstN(rstN),
    .push(strb.loopPush), .pop(strb.loopPop), .wrTop(strb.loopDec),
    .din(loopDin), .topVal(loopTop), .isEmpty(loopEmpty),
    .overflow(loopOverflow), .underflow(loopUnderflow)
  );
endmodule

// File: rtl/pipeSequencer.sv
module pipeSequencer
  import seqPkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          CNT_W      = 16,
  parameter int          PC_DEPTH   = 16,
  parameter int          LOOP_DEPTH = 6,
  parameter int unsigned RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic [2:0]        opKind,
  input  logic              delayed,
  input  logic              condGiven,
  input  logic              condTrue,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [ADDR_W-1:0] loopEnd,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic              loopUseCnt,
  input  logic              loopExitCond,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] decodeAddr,
  output logic [ADDR_W-1:0] execAddr,
  output logic              squashDecode,
  output logic              squashExec,
  output logic              pcOverflow,
  output logic              pcUnderflow,
  output logic              loopOverflow,
  output logic              loopUnderflow
);
  seqStrobe_t strb;
  logic decodeValid, execValid, atLoopEnd, loopTopUseCnt, loopCntLast, pcEmpty;

  assign squashDecode = !decodeValid;
  assign squashExec   = !execValid;

  seqControl ctrl (
    .stall(stall), .opKind(opKind), .delayed(delayed),
    .condGiven(condGiven), .condTrue(condTrue), .loopExitCond(loopExitCond),
    .execValid(execValid), .atLoopEnd(atLoopEnd), .loopTopUseCnt(loopTopUseCnt),
    .loopCntLast(loopCntLast), .pcEmpty(pcEmpty), .strb(strb)
  );

  seqDatapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PC_DEPTH(PC_DEPTH),
    .LOOP_DEPTH(LOOP_DEPTH), .RESET_ADDR(RESET_ADDR)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .target(branchTarget),
    .loopEnd(loopEnd), .loopCount(loopCount), .loopUseCnt(loopUseCnt),
    .fetchAddr(fetchAddr), .decodeAddr(decodeAddr), .execAddr(execAddr),
    .decodeValid(decodeValid), .execValid(execValid), .atLoopEnd(atLoopEnd),
    .loopTopUseCnt(loopTopUseCnt), .loopCntLast(loopCntLast), .pcEmpty(pcEmpty),
    .pcOverflow(pcOverflow), .pcUnderflow(pcUnderflow),
    .loopOverflow(loopOverflow), .loopUnderflow(loopUnderflow)
  );
endmodule

// File: rtl/seqChecker.sv
module seqChecker
  import seqPkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input seqStrobe_t        strb,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [ADDR_W-1:0] decodeAddr,
  input logic              squashDecode,
  input logic              squashExec,
  input logic              pcOverflow,
  input logic              loopOverflow
);
  // R2
  decode_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> decodeAddr == $past(fetchAddr));

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> fetchAddr == $past(fetchAddr));

  // R4
  young_squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.killYoung |=> squashDecode && squashExec);

  // R5
  no_kill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.killYoung) |=> !squashDecode);

  // R13
  pc_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcOverflow |=> pcOverflow);

  // R13
  loop_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopOverflow |=> loopOverflow);
endmodule

bind pipeSequencer seqChecker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .stall(stall), .strb(strb),
  .fetchAddr(fetchAddr), .decodeAddr(decodeAddr),
  .squashDecode(squashDecode), .squashExec(squashExec),
  .pcOverflow(pcOverflow), .loopOverflow(loopOverflow)
);

// File: tb/pipeSequencer_test.sv
module pipeSequencer_test;
  localparam int AW = 12;
  localparam int CW = 16;
  localparam logic [2:0] K_NONE = 3'd0, K_JUMP = 3'd1, K_CALL = 3'd2,
                         K_RET = 3'd3, K_LOOP = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b0;
  logic [2:0] opKind = K_NONE;
  logic delayed = 1'b0, condGiven = 1'b0, condTrue = 1'b0;
  logic [AW-1:0] branchTarget = '0, loopEnd = '0;
  logic [CW-1:0] loopCount = '0;
  logic loopUseCnt = 1'b0, loopExitCond = 1'b0;
  logic [AW-1:0] fetchAddr, decodeAddr, execAddr;
  logic squashDecode, squashExec, pcOverflow, pcUnderflow, loopOverflow, loopUnderflow;

  int checks = 0;
  int failures = 0;

  pipeSequencer uut (
    .clk(clk), .rstN(rstN), .stall(stall), .opKind(opKind), .delayed(delayed),
    .condGiven(condGiven), .condTrue(condTrue), .branchTarget(branchTarget),
    .loopEnd(loopEnd), .loopCount(loopCount), .loopUseCnt(loopUseCnt),
    .loopExitCond(loopExitCond), .fetchAddr(fetchAddr), .decodeAddr(decodeAddr),
    .execAddr(execAddr), .squashDecode(squashDecode), .squashExec(squashExec),
    .pcOverflow(pcOverflow), .pcUnderflow(pcUnderflow),
    .loopOverflow(loopOverflow), .loopUnderflow(loopUnderflow)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    opKind = K_NONE; delayed = 1'b0; condGiven = 1'b0; condTrue = 1'b0;
    branchTarget = '0; loopEnd = '0; loopCount = '0; loopUseCnt = 1'b0;
  endtask

  task automatic setOp(input logic [2:0] k, input bit dly, input bit cg, input bit ct,
                       input int tgt, input int lend, input int lcnt, input bit useCnt);
    opKind = k; delayed = dly; condGiven = cg; condTrue = ct;
    branchTarget = AW'(tgt); loopEnd = AW'(lend); loopCount = CW'(lcnt); loopUseCnt = useCnt;
  endtask

  task automatic stepTo(input int addr);
    while (!(execAddr == AW'(addr) && !squashExec)) tick();
  endtask

  task automatic resetTest();
    rstN = 1'b0;
    repeat (3) tick();
    chk("R1", "fetchAddr", fetchAddr, 0);
    chk("R1", "squashDecode", squashDecode, 1);
    chk("R1", "squashExec", squashExec, 1);
    chk("R1", "flags", {pcOverflow, pcUnderflow, loopOverflow, loopUnderflow}, 0);
    rstN = 1'b1;
    tick(); tick();
    chk("R2", "fetchAddr", fetchAddr, 2);
    chk("R2", "decodeAddr", decodeAddr, 1);
    chk("R2", "execAddr", execAddr, 0);
    chk("R2", "squashExec", squashExec, 0);
  endtask

  task automatic jumpTest();
    stepTo(4);
    setOp(K_JUMP, 0, 1, 1, 20, 0, 0, 0);
    tick();
    chk("R4", "fetch target", fetchAddr, 20);
    chk("R4", "squashDecode", squashDecode, 1);
    chk("R4", "squashExec", squashExec, 1);
    setOp(K_JUMP, 0, 1, 1, 99, 0, 0, 0);   // execute slot squashed: ignored
    tick();
    idle();
    chk("R8", "fetch after squashed jump", fetchAddr, 21);
    tick();
    chk("R4", "execAddr target", execAddr, 20);
    chk("R4", "squashExec target", squashExec, 0);
  endtask

  task automatic condTest();
    stepTo(22);
    setOp(K_JUMP, 0, 1, 0, 50, 0, 0, 0);
    tick();
    idle();
    chk("R6", "not taken fetch", fetchAddr, 25);
    chk("R6", "not taken squash", squashDecode, 0);
    stepTo(25);
    setOp(K_JUMP, 0, 0, 0, 40, 0, 0, 0);
    tick();
    idle();
    chk("R6", "default condition fetch", fetchAddr, 40);
  endtask

  task automatic stallTest();
    stepTo(42);
    stall = 1'b1;
    setOp(K_JUMP, 0, 1, 1, 90, 0, 0, 0);
    tick();
    chk("R3", "fetch held", fetchAddr, 44);
    chk("R3", "decode held", decodeAddr, 43);
    chk("R3", "exec held", execAddr, 42);
    stall = 1'b0;
    idle();
    tick();
    chk("R3", "fields ignored under stall", fetchAddr, 45);
    chk("R2", "exec advance", execAddr, 43);
  endtask

  task automatic callTest();
    stepTo(46);
    setOp(K_CALL, 0, 1, 1, 60, 0, 0, 0);
    tick(); idle();
    chk("R4", "call target", fetchAddr, 60);
    stepTo(60);
    setOp(K_CALL, 1, 1, 1, 80, 0, 0, 0);
    tick(); idle();
    chk("R5", "delayed call target", fetchAddr, 80);
    chk("R5", "exec slot kept", execAddr, 61);
    chk("R5", "exec not squashed", squashExec, 0);
    chk("R5", "decode not squashed", squashDecode, 0);
    stepTo(80);
    setOp(K_RET, 0, 0, 0, 0, 0, 0, 0);
    tick(); idle();
    chk("R7", "return to n+3", fetchAddr, 63);
    stepTo(63);
    setOp(K_RET, 1, 0, 0, 0, 0, 0, 0);
    tick(); idle();
    chk("R7", "return to n+1", fetchAddr, 47);
    chk("R5", "delayed return no squash", squashDecode, 0);
  endtask

  task automatic countLoopTest();
    int expSeq[12] = '{52, 53, 50, 51, 52, 53, 50, 51, 52, 53, 54, 55};
    stepTo(49);
    setOp(K_LOOP, 0, 0, 0, 0, 53, 3, 1);
    tick(); idle();
    for (int i = 0; i < 12; i++) begin
      chk("R9", "counted loop fetch", fetchAddr, expSeq[i]);
      chk("R9", "no bubble", squashDecode, 0);
      tick();
    end
  endtask

  task automatic condLoopTest();
    int expSeq[6] = '{59, 57, 58, 59, 60, 61};
    int hits = 0;
    stepTo(56);
    setOp(K_LOOP, 0, 0, 0, 0, 59, 0, 0);
    tick(); idle();
    for (int i = 0; i < 6; i++) begin
      chk("R10", "condition loop fetch", fetchAddr, expSeq[i]);
      if (fetchAddr == AW'(59)) hits++;
      loopExitCond = (fetchAddr == AW'(59)) && (hits == 2);
      tick();
    end
    loopExitCond = 1'b0;
  endtask

  task automatic collideTest();
    int expSeq[9] = '{63, 64, 65, 66, 63, 64, 65, 66, 67};
    stepTo(62);
    setOp(K_LOOP, 0, 0, 0, 0, 66, 2, 1);
    tick(); idle();
    tick();
    chk("R11", "loop end in fetch", fetchAddr, 66);
    chk("R11", "jump slot in exec", execAddr, 64);
    setOp(K_JUMP, 0, 1, 1, 63, 0, 0, 0);
    tick(); idle();
    for (int i = 0; i < 9; i++) begin
      chk("R11", "branch beats loop test", fetchAddr, expSeq[i]);
      tick();
    end
  endtask

  task automatic underflowTest();
    stepTo(70);
    setOp(K_RET, 0, 0, 0, 0, 0, 0, 0);
    tick(); idle();
    chk("R12", "stacks popped on exit, no redirect", fetchAddr, 73);
    chk("R13", "pcUnderflow", pcUnderflow, 1);
    chk("R13", "no squash on empty return", squashDecode, 0);
    chk("R12", "loopUnderflow", loopUnderflow, 0);
  endtask

  task automatic loopOverflowTest();
    int expSeq[5] = '{83, 84, 85, 86, 87};
    stepTo(74);
    for (int i = 0; i < 6; i++) begin
      setOp(K_LOOP, 0, 0, 0, 0, 3000 + i, 5, 1);
      tick();
    end
    setOp(K_LOOP, 0, 0, 0, 0, 85, 2, 1);
    tick(); idle();
    chk("R13", "loopOverflow", loopOverflow, 1);
    chk("R13", "pcOverflow clear", pcOverflow, 0);
    for (int i = 0; i < 5; i++) begin
      chk("R13", "rejected loop has no effect", fetchAddr, expSeq[i]);
      tick();
    end
  endtask

  task automatic pcOverflowTest();
    stepTo(88);
    for (int i = 0; i < 10; i++) begin
      setOp(K_CALL, 1, 1, 1, 91 + i, 0, 0, 0);
      tick();
    end
    idle();
    chk("R13", "pcOverflow", pcOverflow, 1);
    chk("R13", "fetch after calls", fetchAddr, 100);
    chk("R13", "loopOverflow still set", loopOverflow, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick();
    resetTest();
    jumpTest();
    condTest();
    stallTest();
    callTest();
    countLoopTest();
    condLoopTest();
    collideTest();
    underflowTest();
    loopOverflowTest();
    pcOverflowTest();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule